// File: doc/BRIEF.md
# Legacy Low-Memory Route Decoder

This block classifies every access that falls in the first megabyte of the physical address space. Given a 20-bit address and a read/write flag, it returns at once where the access must go. There are three targets: system RAM, RAM that may only be read, or the PCI bus. The choice comes from a set of attribute fields and from a system-management RAM control byte. Software loads these through a byte-wide configuration write port.

The upper 256 KB holds twelve 16 KB option-ROM segments and one 64 KB firmware segment. Each has a 2-bit attribute. The 128 KB window starting at 0xA0000 is shown as RAM or passed to PCI. That depends on two things: an "always open" bit, and a bit that opens the window only while the processor's SMM-active input is high. A write that lands on a read-only segment is marked as discarded, so the memory side can drop it. The block also keeps a DRAM size byte for the platform to use.

Top module: `lowmem_route_decoder`

## Requirements
- R1: After reset, every 16 KB segment and the 64 KB top segment route to PCI. The SMRAM control byte is 0x02, so the 0xA0000–0xBFFFF window routes to PCI whatever the SMM input is. The size output equals min(RAM_MBYTES/8, 255), which is 255 for the defaults.
- R2: Any address below 0xA0000 routes to RAM, whatever the configuration.
- R3: The route output uses code 0 for RAM, 1 for read-only RAM and 2 for PCI, and never shows 3. A 2-bit attribute value of 3 selects RAM, 1 selects read-only RAM, and 0 or 2 select PCI.
- R4: The discard flag is high exactly when the request is a write (reqWrite=1) and its route is read-only RAM.
- R5: Addresses 0xF0000–0xFFFFF are governed by bits [5:4] of the byte written at offset 0x59.
- R6: Segment i (0..11) covers 0xC0000+0x4000*i to 0xC0000+0x4000*(i+1)-1. Its attribute is bits [1:0] of the low nibble (even i) or bits [5:4] (odd i) of the byte at offset 0x5A+i/2.
- R7: The 0xA0000–0xBFFFF window routes to RAM when bit 6 of the byte at offset 0x72 is set, or when bit 3 of that byte is set and smmActive is high. In every other case it routes to PCI.
- R8: A change on smmActive or on the request changes the outputs in the same cycle. A configuration write takes effect in the cycle after the clock edge that captures it.
- R9: A write at offset 0x57 replaces the 8-bit DRAM size value on ramSizeUnits.
- R10: Configuration writes to any other offset leave every route unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgOffset | input | 8 | Configuration byte offset |
| cfgData | input | 8 | Configuration byte data |
| smmActive | input | 1 | Processor is in system-management mode |
| reqAddr | input | 20 | Access address |
| reqWrite | input | 1 | Access is a write |
| route | output | 2 | Target code (0 RAM, 1 read-only RAM, 2 PCI) |
| wrDiscard | output | 1 | Write hits read-only RAM and must be dropped |
| ramSizeUnits | output | 8 | DRAM size in 8 MB units |

## Verification
Some properties are checked on every cycle by the assertions. These are: the low 640 KB always routes to RAM, the route code is never 3, a read is never marked as discarded, and the size byte follows a write to it. They also check the window routing in the cycle after a control write that opens it or closes it fully. Other behaviour can only be shown by the bench's scenarios. That covers the nibble position of each 16 KB segment, the distinct meaning of each attribute value, and the two-condition SMM opening of the window, including a same-cycle response to an SMM toggle. The reset of all state in the middle of a run is also left to the bench.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int SEG_COUNT = 12;
  localparam int SEG_REGS = SEG_COUNT / 2;
  localparam logic [7:0] TOP_ATTR_OFF = 8'h59;
  localparam logic [7:0] SEG_ATTR_OFF = 8'h5A;
  localparam logic [7:0] SMRAM_OFF = 8'h72;
  localparam logic [7:0] SIZE_OFF = 8'h57;
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam logic [19:0] WIN_LO = 20'hA0000;
  localparam logic [19:0] ROM_LO = 20'hC0000;
  localparam logic [19:0] TOP_LO = 20'hF0000;
  localparam int SEG_SHIFT = 14;

  typedef enum logic [1:0] {
    ROUTE_RAM = 2'd0,
    ROUTE_ROM = 2'd1,
    ROUTE_PCI = 2'd2
  } route_e;

  typedef struct packed {
    logic topWr;
    logic [SEG_COUNT-1:0] segWr;
    logic smramWr;
    logic sizeWr;
  } strobe_t;

  function automatic route_e attrRoute(input logic [1:0] code);
    case (code)
      2'd3: attrRoute = ROUTE_RAM;
      2'd1: attrRoute = ROUTE_ROM;
      default: attrRoute = ROUTE_PCI;
    endcase
  endfunction
endpackage

// File: rtl/lmr_ctrl.sv
module lmr_ctrl
  import lmr_pkg::*;
(
  input  logic       cfgWrEn,
  input  logic [7:0] cfgOffset,
  output strobe_t    strobes
);
  always_comb begin
    strobes.topWr = cfgWrEn && (cfgOffset == TOP_ATTR_OFF);
    strobes.smramWr = cfgWrEn && (cfgOffset == SMRAM_OFF);
    strobes.sizeWr = cfgWrEn && (cfgOffset == SIZE_OFF);
  end

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_segStb
    assign strobes.segWr[i] = cfgWrEn && (cfgOffset == SEG_ATTR_OFF + 8'(i / 2));
  end
endmodule

// File: rtl/lmr_datapath.sv
module lmr_datapath
  import lmr_pkg::*;
#(
  parameter logic [7:0] SIZE_RST = 8'd255
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobes,
  input  logic [7:0]  cfgData,
  input  logic        smmActive,
  input  logic [19:0] reqAddr,
  input  logic        reqWrite,
  output logic [1:0]  route,
  output logic        wrDiscard,
  output logic [7:0]  ramSizeUnits
);
  localparam logic [5:0] SEG_FIRST = 6'(ROM_LO >> SEG_SHIFT);

  logic [1:0] topAttr;
  logic [1:0] segAttr [SEG_COUNT];
  logic [7:0] smramCtl;
  logic [7:0] sizeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topAttr <= 2'd0;
      smramCtl <= SMRAM_RST;
      sizeReg <= SIZE_RST;
    end else begin
      if (strobes.topWr) topAttr <= cfgData[5:4];
      if (strobes.smramWr) smramCtl <= cfgData;
      if (strobes.sizeWr) sizeReg <= cfgData;
    end
  end

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    localparam int LSB = (i % 2) * 4;
    always_ff @(posedge clk) begin
      if (!rstN) segAttr[i] <= 2'd0;
      else if (strobes.segWr[i]) segAttr[i] <= cfgData[LSB +: 2];
    end
  end

  logic [5:0] segIdx;
  logic [1:0] segCode;
  logic       winOpen;
  route_e     routeNext;

  always_comb begin
    segIdx = reqAddr[19:SEG_SHIFT] - SEG_FIRST;
    segCode = 2'd0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (segIdx == 6'(i)) segCode = segAttr[i];
    end
    winOpen = smramCtl[6] || (smramCtl[3] && smmActive);
    if (reqAddr < WIN_LO) routeNext = ROUTE_RAM;
    else if (reqAddr < ROM_LO) routeNext = winOpen ? ROUTE_RAM : ROUTE_PCI;
    else if (reqAddr < TOP_LO) routeNext = attrRoute(segCode);
    else routeNext = attrRoute(topAttr);
  end

  assign route = routeNext;
  assign wrDiscard = reqWrite && (routeNext == ROUTE_ROM);
  assign ramSizeUnits = sizeReg;
endmodule

// File: rtl/lowmem_route_decoder.sv
module lowmem_route_decoder
  import lmr_pkg::*;
#(
  parameter int RAM_MBYTES = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgOffset,
  input  logic [7:0]  cfgData,
  input  logic        smmActive,
  input  logic [19:0] reqAddr,
  input  logic        reqWrite,
  output logic [1:0]  route,
  output logic        wrDiscard,
  output logic [7:0]  ramSizeUnits
);
  localparam int SIZE_UNITS = RAM_MBYTES / 8;
  localparam logic [7:0] SIZE_RST = (SIZE_UNITS > 255) ? 8'd255 : 8'(SIZE_UNITS);

  strobe_t strobes;

  lmr_ctrl i_ctrl (
    .cfgWrEn(cfgWrEn),
    .cfgOffset(cfgOffset),
    .strobes(strobes)
  );

  lmr_datapath #(.SIZE_RST(SIZE_RST)) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .cfgData(cfgData),
    .smmActive(smmActive),
    .reqAddr(reqAddr),
    .reqWrite(reqWrite),
    .route(route),
    .wrDiscard(wrDiscard),
    .ramSizeUnits(ramSizeUnits)
  );
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [7:0]  cfgOffset,
  input logic [7:0]  cfgData,
  input logic [19:0] reqAddr,
  input logic        reqWrite,
  input logic [1:0]  route,
  input logic        wrDiscard,
  input logic [7:0]  ramSizeUnits
);
  logic inWin;
  assign inWin = (reqAddr >= 20'hA0000) && (reqAddr < 20'hC0000);

  // R2: conventional memory always reaches RAM
  a_r2_low_ram: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr < 20'hA0000) |-> (route == 2'd0));

  // R3: code 3 is never produced
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    route != 2'd3);

  // R4: reads are never discarded
  a_r4_read_kept: assert property (@(posedge clk) disable iff (!rstN)
    !reqWrite |-> !wrDiscard);

  // R7: always-open bit maps the window to RAM in the following cycle
  a_r7_win_open: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgWrEn && cfgOffset == 8'h72 && cfgData[6]) && inWin) |-> (route == 2'd0));

  // R7: a zero control byte sends the window to PCI in the following cycle
  a_r7_win_closed: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgWrEn && cfgOffset == 8'h72 && cfgData == 8'h00) && inWin) |-> (route == 2'd2));

  // R9: size byte follows its write
  a_r9_size_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn && cfgOffset == 8'h57) |-> (ramSizeUnits == $past(cfgData)));
endmodule

bind lowmem_route_decoder lmr_checker i_chk (
  .clk(clk),
  .rstN(rstN),
  .cfgWrEn(cfgWrEn),
  .cfgOffset(cfgOffset),
  .cfgData(cfgData),
  .reqAddr(reqAddr),
  .reqWrite(reqWrite),
  .route(route),
  .wrDiscard(wrDiscard),
  .ramSizeUnits(ramSizeUnits)
);

// File: tb/test_lowmem_route_decoder.sv
module test_lowmem_route_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgOffset = 8'h00;
  logic [7:0]  cfgData = 8'h00;
  logic        smmActive = 1'b0;
  logic [19:0] reqAddr = 20'h0;
  logic        reqWrite = 1'b0;
  logic [1:0]  route;
  logic        wrDiscard;
  logic [7:0]  ramSizeUnits;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lowmem_route_decoder i_lowmem_route_decoder (.*);

  typedef struct packed {
    logic        doWr;
    logic [7:0]  off;
    logic [7:0]  dat;
    logic        smm;
    logic [19:0] addr;
    logic        isWr;
    logic [1:0]  expRoute;
    logic        expDisc;
  } vec_t;

  // route codes: 0 RAM, 1 read-only RAM, 2 PCI
  localparam vec_t VEC [17] = '{
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'h12345, 1'b1, 2'd0, 1'b0}, // R2
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'hA0000, 1'b0, 2'd2, 1'b0}, // R1 window
    '{1'b0, 8'h00, 8'h00, 1'b1, 20'hB0000, 1'b0, 2'd2, 1'b0}, // R1 smm w/o bit3
    '{1'b1, 8'h72, 8'h08, 1'b0, 20'hA8000, 1'b0, 2'd2, 1'b0}, // R7 bit3, no smm
    '{1'b0, 8'h00, 8'h00, 1'b1, 20'hA8000, 1'b0, 2'd0, 1'b0}, // R7 bit3 + smm
    '{1'b1, 8'h72, 8'h40, 1'b0, 20'hBFFFF, 1'b0, 2'd0, 1'b0}, // R7 bit6
    '{1'b1, 8'h59, 8'h30, 1'b0, 20'hF1234, 1'b1, 2'd0, 1'b0}, // R5 code 3
    '{1'b1, 8'h59, 8'h10, 1'b0, 20'hFFFFF, 1'b1, 2'd1, 1'b1}, // R5 R4 code 1
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'hF0000, 1'b0, 2'd1, 1'b0}, // R4 read of ROM
    '{1'b1, 8'h5A, 8'h31, 1'b0, 20'hC0000, 1'b1, 2'd1, 1'b1}, // R6 seg0 low nibble
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'hC4000, 1'b1, 2'd0, 1'b0}, // R6 seg1 high nibble
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'hC8000, 1'b0, 2'd2, 1'b0}, // R6 seg2 untouched
    '{1'b1, 8'h5F, 8'h12, 1'b0, 20'hEC000, 1'b0, 2'd1, 1'b0}, // R6 seg11
    '{1'b0, 8'h00, 8'h00, 1'b0, 20'hE8000, 1'b1, 2'd2, 1'b0}, // R3 code 2 -> PCI
    '{1'b1, 8'h58, 8'hFF, 1'b0, 20'hC8000, 1'b0, 2'd2, 1'b0}, // R10 other offset
    '{1'b1, 8'h5B, 8'h03, 1'b0, 20'hCBFFF, 1'b1, 2'd0, 1'b0}, // R6 seg2 edge
    '{1'b1, 8'h5A, 8'h02, 1'b0, 20'hC3FFF, 1'b1, 2'd2, 1'b0}  // R3 code 2, seg0
  };

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] off, input logic [7:0] dat);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgOffset = off;
    cfgData = dat;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(input logic [19:0] a, input logic w);
    reqAddr = a;
    reqWrite = w;
    #1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 size reset", ramSizeUnits, 8'd255);
    probe(20'hC0000, 1'b0);
    checkVal("R1 seg reset", route, 2);
    probe(20'hF8000, 1'b0);
    checkVal("R1 top reset", route, 2);

    foreach (VEC[k]) begin
      if (VEC[k].doWr) cfgWrite(VEC[k].off, VEC[k].dat);
      else @(negedge clk);
      smmActive = VEC[k].smm;
      probe(VEC[k].addr, VEC[k].isWr);
      checkVal($sformatf("vector %0d route", k), route, VEC[k].expRoute);
      checkVal($sformatf("vector %0d discard R4", k), wrDiscard, VEC[k].expDisc);
    end

    // R8: same-cycle response to SMM, bit3-only control
    cfgWrite(8'h72, 8'h08);
    smmActive = 1'b0;
    probe(20'hA0000, 1'b0);
    checkVal("R8 smm low", route, 2);
    smmActive = 1'b1;
    #1;
    checkVal("R8 smm rise same cycle", route, 0);
    smmActive = 1'b0;
    #1;
    checkVal("R8 smm fall same cycle", route, 2);

    // R8: write takes effect only after the capturing edge
    @(negedge clk);
    cfgWrEn = 1'b1; cfgOffset = 8'h72; cfgData = 8'h40;
    #1;
    checkVal("R8 before edge", route, 2);
    @(negedge clk);
    cfgWrEn = 1'b0;
    checkVal("R8 after edge", route, 0);

    // R9: size register write
    cfgWrite(8'h57, 8'h40);
    checkVal("R9 size write", ramSizeUnits, 8'h40);

    // R1: reset in the middle of a run restores everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    smmActive = 1'b1;
    probe(20'hA4000, 1'b0);
    checkVal("R1 window after reset", route, 2);
    probe(20'hCC000, 1'b1);
    checkVal("R1 seg after reset", route, 2);
    checkVal("R1 discard after reset", wrDiscard, 0);
    checkVal("R1 size after reset", ramSizeUnits, 8'd255);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule